// File: doc/BRIEF.md
# Serial ADC Host Interface Controller

This controller is the host side of a three-wire link to a 12-bit serial converter: an active-low convert strobe, a serial clock and a serial data return. On each request it pulls the strobe low, runs a frame of serial clock pulses derived from the system clock through a programmable divider, shifts in the 12-bit result most significant bit first, and presents it with a one-cycle valid pulse. The result is zero-extended for straight-binary parts or sign-extended for two's-complement parts, as selected by an input.

The converter's power state is changed only by where the strobe is raised inside a frame. A sleep command runs a short frame that raises the strobe after the 4th rising clock edge: from normal operation this reaches partial power-down, and from partial power-down it reaches full power-down. A wake command runs a full-length frame with the strobe held low, which returns the converter to normal. The controller keeps its own record of the assumed power state, and a convert request issued while asleep runs a wake frame first. With the continuous input set, the controller raises the strobe between the 15th and 16th rising edges and starts the next frame by itself.

Top module: `serialAdcHost`

## Requirements
- R1: A convert command accepted in the normal power state drops `convN` while `sclk` is low, produces exactly 16 rising `sclk` edges with `convN` low, then raises `convN`.
- R2: Each `sclk` level lasts `divRatio`+1 system clocks inside a frame, so consecutive rising edges are 2*(`divRatio`+1) clocks apart; while idle `sclk` is held low and `convN` high.
- R3: The bit present on `serIn` at rising edges 4 through 15 is captured as result bits 11 down to 0; the three leading bits and the 16th bit are discarded.
- R4: With `twosComp`=0 the 12-bit result appears in `resultData` zero-extended to 16 bits; with `twosComp`=1 bit 11 is copied into bits 15:12.
- R5: `resultValid` is a single-cycle pulse, given once per conversion frame and never for wake or sleep frames.
- R6: `cmdOp`=1 (sleep) runs a frame of exactly 4 rising `sclk` edges before `convN` rises; from `pwrState`=0 (normal) it moves to 1 (partial).
- R7: Sleep from `pwrState`=1 moves to 2 (full); sleep in state 2 leaves it at 2; state 2 is only entered from state 1.
- R8: `cmdOp`=2 (wake) runs a 16-edge frame with `convN` low, gives no result and sets `pwrState` to 0.
- R9: `cmdOp`=0 (convert) issued with `pwrState` nonzero runs a wake frame and then a conversion frame, yields exactly one result (from the second frame) and leaves `pwrState` at 0.
- R10: While `contEn`=1, a conversion frame raises `convN` after its 15th and before its 16th rising edge, and a new conversion frame starts without a new command; each frame yields one result.
- R11: `busy` is high from the cycle after a command is accepted until the last frame ends and `cmdReady` is its inverse; commands presented while busy, and `cmdOp`=3 at any time, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command strobe, taken when `cmdReady` is high |
| cmdOp | input | 2 | 0 convert, 1 sleep, 2 wake, 3 reserved |
| contEn | input | 1 | Keep converting back to back while high |
| twosComp | input | 1 | Result coding: 1 sign-extends, 0 zero-extends |
| divRatio | input | 8 | Serial clock half-period minus one, in system clocks |
| serIn | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock to the converter |
| convN | output | 1 | Active-low convert strobe |
| cmdReady | output | 1 | Controller idle, command can be taken |
| busy | output | 1 | A frame sequence is in progress |
| pwrState | output | 2 | Assumed converter state: 0 normal, 1 partial, 2 full |
| resultValid | output | 1 | One-cycle pulse with a new result |
| resultData | output | 16 | Extended conversion result |

## Verification
The assertions assume the converter launches each data bit on the falling `sclk` edge so that the bit is stable for the whole following high phase, and that `divRatio` does not change while a frame is running. The bench models the converter as a shift register reloaded on each falling `convN` edge and advanced on each falling `sclk` edge, and it only changes `divRatio` or `twosComp` while the controller is idle. Commands are driven away from the clock edge and held for one cycle, so a command lands either while idle or wholly inside a busy interval.

// File: rtl/serialAdcPkg.sv
package serialAdcPkg;

  localparam logic [1:0] OP_CONVERT = 2'd0;
  localparam logic [1:0] OP_SLEEP   = 2'd1;
  localparam logic [1:0] OP_WAKE    = 2'd2;
  localparam logic [1:0] OP_RSVD    = 2'd3;

  typedef enum logic [1:0] {
    PWR_ON      = 2'd0,
    PWR_PARTIAL = 2'd1,
    PWR_FULL    = 2'd2
  } pwrState_e;

  typedef enum logic [1:0] {
    K_CONV  = 2'd0,
    K_WAKE  = 2'd1,
    K_SHORT = 2'd2
  } frameKind_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LEAD = 3'd1,
    ST_HI   = 3'd2,
    ST_LO   = 3'd3,
    ST_GAP  = 3'd4
  } seqState_e;

  typedef struct packed {
    logic run;
    logic frameStart;
    logic sclkRise;
    logic sclkFall;
    logic strobeLow;
    logic strobeHigh;
    logic sample;
    logic publish;
  } sadcCtl_t;

endpackage

// File: rtl/sadcDatapath.sv
module sadcDatapath
  import serialAdcPkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int FRAME_EDGES = 16,
  parameter int LEAD_ZEROS  = 3,
  parameter int RES_W       = 12,
  parameter int OUT_W       = 16,
  localparam int EW         = $clog2(FRAME_EDGES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  sadcCtl_t         ctl,
  input  logic [DIV_W-1:0] divRatio,
  input  logic             twosComp,
  input  logic             serIn,
  output logic             tick,
  output logic [EW-1:0]    edgeCnt,
  output logic             sclk,
  output logic             convN,
  output logic             resultValid,
  output logic [OUT_W-1:0] resultData
);

  localparam int FIRST_BIT = LEAD_ZEROS + 1;
  localparam int LAST_BIT  = LEAD_ZEROS + RES_W;

  logic [DIV_W-1:0] divCnt;
  logic [RES_W-1:0] shiftReg;
  logic             inWindow;

  assign tick     = ctl.run && (divCnt == '0);
  assign inWindow = (edgeCnt >= EW'(FIRST_BIT)) && (edgeCnt <= EW'(LAST_BIT));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (!ctl.run) begin
      divCnt <= divRatio;
    end else if (divCnt == '0) begin
      divCnt <= divRatio;
    end else begin
      divCnt <= divCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt <= '0;
    end else if (ctl.frameStart) begin
      edgeCnt <= '0;
    end else if (ctl.sclkRise) begin
      edgeCnt <= edgeCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclk  <= 1'b0;
      convN <= 1'b1;
    end else begin
      if (ctl.sclkRise)        sclk  <= 1'b1;
      else if (ctl.sclkFall)   sclk  <= 1'b0;
      if (ctl.strobeLow)       convN <= 1'b0;
      else if (ctl.strobeHigh) convN <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (ctl.sample && inWindow) begin
      shiftReg <= {shiftReg[RES_W-2:0], serIn};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      resultData  <= '0;
    end else begin
      resultValid <= ctl.publish;
      if (ctl.publish) begin
        if (twosComp) resultData <= {{(OUT_W-RES_W){shiftReg[RES_W-1]}}, shiftReg};
        else          resultData <= {{(OUT_W-RES_W){1'b0}}, shiftReg};
      end
    end
  end

  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  assert_edge_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    edgeCnt <= EW'(FRAME_EDGES));

  assert_sclk_steady_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.run && !tick) |=> $stable(sclk));

endmodule

// File: rtl/sadcControl.sv
module sadcControl
  import serialAdcPkg::*;
#(
  parameter int FRAME_EDGES = 16,
  parameter int SHORT_EDGES = 4,
  localparam int EW         = $clog2(FRAME_EDGES + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic [1:0]    cmdOp,
  input  logic          contEn,
  input  logic          tick,
  input  logic [EW-1:0] edgeCnt,
  output sadcCtl_t      ctl,
  output logic          busy,
  output logic [1:0]    pwrState
);

  seqState_e  state, nState;
  frameKind_e kind, nKind;
  pwrState_e  pwr, nPwr;
  logic       pend, nPend;

  always_comb begin
    ctl     = '0;
    nState  = state;
    nKind   = kind;
    nPend   = pend;
    nPwr    = pwr;
    ctl.run = (state != ST_IDLE);
    case (state)
      ST_IDLE: begin
        if (cmdValid && cmdOp != OP_RSVD) begin
          ctl.frameStart = 1'b1;
          ctl.strobeLow  = 1'b1;
          nState         = ST_LEAD;
          nPend          = 1'b0;
          if (cmdOp == OP_SLEEP)     nKind = K_SHORT;
          else if (cmdOp == OP_WAKE) nKind = K_WAKE;
          else if (pwr != PWR_ON) begin
            nKind = K_WAKE;
            nPend = 1'b1;
          end else                   nKind = K_CONV;
        end
      end
      ST_LEAD: begin
        if (tick) begin
          ctl.sclkRise = 1'b1;
          nState       = ST_HI;
        end
      end
      ST_HI: begin
        if (tick) begin
          ctl.sclkFall = 1'b1;
          ctl.sample   = 1'b1;
          if (kind == K_CONV && contEn && edgeCnt == EW'(FRAME_EDGES - 1))
            ctl.strobeHigh = 1'b1;
          nState = ST_LO;
        end
      end
      ST_LO: begin
        if (tick) begin
          if (kind == K_SHORT && edgeCnt == EW'(SHORT_EDGES)) begin
            ctl.strobeHigh = 1'b1;
            nPwr           = (pwr == PWR_ON) ? PWR_PARTIAL : PWR_FULL;
            nState         = ST_GAP;
          end else if (edgeCnt == EW'(FRAME_EDGES)) begin
            ctl.strobeHigh = 1'b1;
            ctl.publish    = (kind == K_CONV);
            nPwr           = PWR_ON;
            nState         = ST_GAP;
          end else begin
            ctl.sclkRise = 1'b1;
            nState       = ST_HI;
          end
        end
      end
      ST_GAP: begin
        if (tick) begin
          if (pend || (kind == K_CONV && contEn)) begin
            ctl.frameStart = 1'b1;
            ctl.strobeLow  = 1'b1;
            nKind          = K_CONV;
            nPend          = 1'b0;
            nState         = ST_LEAD;
          end else begin
            nState = ST_IDLE;
          end
        end
      end
      default: nState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      kind  <= K_CONV;
      pwr   <= PWR_ON;
      pend  <= 1'b0;
    end else begin
      state <= nState;
      kind  <= nKind;
      pwr   <= nPwr;
      pend  <= nPend;
    end
  end

  assign busy     = (state != ST_IDLE);
  assign pwrState = pwr;

  assert_full_from_partial_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pwr == PWR_FULL && $past(pwr) != PWR_FULL) |-> $past(pwr) == PWR_PARTIAL);

  assert_ignore_when_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdValid && !tick) |=> (state == $past(state) && kind == $past(kind)));

endmodule

// File: rtl/serialAdcHost.sv
module serialAdcHost
  import serialAdcPkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int FRAME_EDGES = 16,
  parameter int SHORT_EDGES = 4,
  parameter int LEAD_ZEROS  = 3,
  parameter int RES_W       = 12,
  parameter int OUT_W       = 16,
  localparam int EW         = $clog2(FRAME_EDGES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic             contEn,
  input  logic             twosComp,
  input  logic [DIV_W-1:0] divRatio,
  input  logic             serIn,
  output logic             sclk,
  output logic             convN,
  output logic             cmdReady,
  output logic             busy,
  output logic [1:0]       pwrState,
  output logic             resultValid,
  output logic [OUT_W-1:0] resultData
);

  sadcCtl_t      ctl;
  logic          tick;
  logic [EW-1:0] edgeCnt;

  sadcControl #(
    .FRAME_EDGES(FRAME_EDGES),
    .SHORT_EDGES(SHORT_EDGES)
  ) u_control (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .contEn   (contEn),
    .tick     (tick),
    .edgeCnt  (edgeCnt),
    .ctl      (ctl),
    .busy     (busy),
    .pwrState (pwrState)
  );

  sadcDatapath #(
    .DIV_W      (DIV_W),
    .FRAME_EDGES(FRAME_EDGES),
    .LEAD_ZEROS (LEAD_ZEROS),
    .RES_W      (RES_W),
    .OUT_W      (OUT_W)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .divRatio    (divRatio),
    .twosComp    (twosComp),
    .serIn       (serIn),
    .tick        (tick),
    .edgeCnt     (edgeCnt),
    .sclk        (sclk),
    .convN       (convN),
    .resultValid (resultValid),
    .resultData  (resultData)
  );

  assign cmdReady = !busy;

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclk && convN));

  assert_strobe_fall_R1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(convN) |-> !sclk);

endmodule

// File: tb/serialAdcHost_tb.sv
module serialAdcHost_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = 2'd0;
  logic        contEn = 1'b0;
  logic        twosComp = 1'b0;
  logic [7:0]  divRatio = 8'd2;
  logic        serIn = 1'b0;
  logic        sclk, convN, cmdReady, busy, resultValid;
  logic [1:0]  pwrState;
  logic [15:0] resultData;

  int vectors = 0;
  int misses  = 0;

  always #10 clk = ~clk;

  serialAdcHost u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .contEn(contEn), .twosComp(twosComp), .divRatio(divRatio), .serIn(serIn),
    .sclk(sclk), .convN(convN), .cmdReady(cmdReady), .busy(busy),
    .pwrState(pwrState), .resultValid(resultValid), .resultData(resultData)
  );

  // converter model: bits {000, D11..D0, 0}, launched on falling sclk
  logic [11:0] pat [0:7];
  logic [15:0] devWord;
  int devIdx = 0;
  int bitIdx = 0;
  int frames = 0;

  initial begin
    pat[0] = 12'hA5C; pat[1] = 12'h3F1; pat[2] = 12'hFFF; pat[3] = 12'h000;
    pat[4] = 12'h800; pat[5] = 12'h7FF; pat[6] = 12'h9A3; pat[7] = 12'h155;
  end

  always @(negedge convN) begin
    devWord = {3'b000, pat[devIdx % 8], 1'b0};
    devIdx++;
    frames++;
    bitIdx = 0;
    serIn <= devWord[15];
  end

  always @(negedge sclk) begin
    bitIdx++;
    serIn <= (bitIdx < 16) ? devWord[15 - bitIdx] : 1'b0;
  end

  // edge and period monitors
  int cyc = 0;
  int riseCnt = 0;
  int lastRiseCyc = 0;
  int lastPeriod = 0;
  int lastEdges = 0;
  always @(posedge clk) cyc++;
  always @(negedge convN) riseCnt = 0;
  always @(posedge sclk) begin
    if (!convN) begin
      if (riseCnt >= 1) lastPeriod = cyc - lastRiseCyc;
      lastRiseCyc = cyc;
      riseCnt++;
    end
  end
  always @(posedge convN) lastEdges = riseCnt;

  int valids = 0;
  logic [15:0] lastRes = '0;
  logic [15:0] resLog [0:15];
  always @(negedge clk) begin
    if (resultValid) begin
      lastRes = resultData;
      resLog[valids % 16] = resultData;
      valids++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] extend(input logic [11:0] d, input logic tc);
    return tc ? {{4{d[11]}}, d} : {4'h0, d};
  endfunction

  task automatic sendCmd(input logic [1:0] op);
    @(negedge clk);
    cmdOp = op;
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 20000) check("R11 busy timeout", 1, 0);
    @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R11 reset cmdReady", cmdReady, 1);
    check("R11 reset busy", busy, 0);
    check("R2 reset sclk", sclk, 0);
    check("R2 reset convN", convN, 1);
    check("R7 reset pwrState", pwrState, 0);
    check("R5 reset resultValid", resultValid, 0);
  endtask

  task automatic testConvert(input logic tc, input logic [7:0] div);
    int s, v0, f0;
    @(negedge clk);
    twosComp = tc;
    divRatio = div;
    s = devIdx; v0 = valids; f0 = frames;
    sendCmd(2'd0);
    check("R11 busy after accept", busy, 1);
    check("R11 cmdReady low", cmdReady, 0);
    waitIdle();
    check("R1 rising edges in frame", lastEdges, 16);
    check("R1 one frame", frames - f0, 1);
    check("R2 sclk period", lastPeriod, 2 * (div + 1));
    check("R5 one valid", valids - v0, 1);
    check("R3 R4 result", lastRes, extend(pat[s % 8], tc));
    check("R2 idle sclk low", sclk, 0);
  endtask

  task automatic testSleep(input logic [1:0] expPwr);
    int v0;
    v0 = valids;
    sendCmd(2'd1);
    waitIdle();
    check("R6 short frame edges", lastEdges, 4);
    check("R7 power state after sleep", pwrState, expPwr);
    check("R5 no valid on sleep", valids - v0, 0);
  endtask

  task automatic testWake();
    int v0;
    v0 = valids;
    sendCmd(2'd2);
    waitIdle();
    check("R8 wake edges", lastEdges, 16);
    check("R8 wake power state", pwrState, 0);
    check("R8 no valid on wake", valids - v0, 0);
  endtask

  task automatic testConvertAsleep();
    int s, v0, f0;
    testSleep(2'd1);
    testSleep(2'd2);
    twosComp = 1'b1;
    s = devIdx; v0 = valids; f0 = frames;
    sendCmd(2'd0);
    waitIdle();
    check("R9 frames wake plus convert", frames - f0, 2);
    check("R9 one valid", valids - v0, 1);
    check("R9 result from second frame", lastRes, extend(pat[(s + 1) % 8], 1'b1));
    check("R9 power state normal", pwrState, 0);
  endtask

  task automatic testContinuous();
    int s, v0, f0, n;
    @(negedge clk);
    twosComp = 1'b0;
    contEn = 1'b1;
    s = devIdx; v0 = valids; f0 = frames;
    sendCmd(2'd0);
    n = 0;
    while (valids < v0 + 1 && n < 20000) begin @(negedge clk); n++; end
    check("R10 strobe raised at edge 15", lastEdges, 15);
    while (valids < v0 + 3 && n < 20000) begin @(negedge clk); n++; end
    contEn = 1'b0;
    waitIdle();
    check("R10 three frames", frames - f0, 3);
    check("R10 three results", valids - v0, 3);
    for (int k = 0; k < 3; k++)
      check("R10 result sequence", resLog[(v0 + k) % 16], extend(pat[(s + k) % 8], 1'b0));
  endtask

  task automatic testIgnore();
    int f0;
    f0 = frames;
    sendCmd(2'd0);
    repeat (5) @(negedge clk);
    sendCmd(2'd1);
    waitIdle();
    check("R11 command while busy ignored frames", frames - f0, 1);
    check("R11 command while busy ignored pwr", pwrState, 0);
    sendCmd(2'd3);
    check("R11 reserved op not accepted", busy, 0);
    repeat (4) @(negedge clk);
    check("R11 reserved op no frame", frames - f0, 1);
  endtask

  initial begin
    #200000000;
    check("watchdog expired", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testConvert(1'b0, 8'd2);
    testConvert(1'b1, 8'd2);
    testConvert(1'b1, 8'd0);
    testConvert(1'b0, 8'd5);
    testSleep(2'd1);
    testSleep(2'd2);
    testSleep(2'd2);
    testWake();
    testConvertAsleep();
    testContinuous();
    testIgnore();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule